// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Front End

This block sits between a host register port and the DMA engine of one IDE-style bus-master channel. It holds a command byte with a start bit and a transfer-direction bit, and a status byte with an active flag and an interrupt flag. It also holds a 32-bit base pointer to the descriptor table, which the host writes one byte lane at a time. The block turns changes of the start bit into one-cycle kick and stop requests for the engine. On a kick it hands the engine a descriptor pointer reloaded from the base.

Clearing the start bit does not cut a transfer short. While the engine reports a transfer in flight, the channel stays active. The active flag drops only once the engine goes idle. The drive's interrupt line passes straight through to the host, and each rising edge is recorded in the status byte until the host clears it.

Top module: `bmdma_regs`

## Requirements
- R1: A command write whose start bit (bit 0) equals the stored start bit produces no kick and no stop pulse, leaves the active flag unchanged and does not reload the descriptor pointer.
- R2: A command write that takes the start bit from 0 to 1 loads the descriptor pointer from the base register at that clock edge. If the channel was not active, it sets the active flag (status bit 0) and raises the kick output for exactly the following cycle. If the channel was already active, no kick is issued.
- R3: A command write that takes the start bit from 1 to 0 raises the stop output for the following cycle. If the engine reports no transfer in flight, the active flag clears at that edge. Otherwise the flag stays set until the first edge at which the engine is idle, and is cleared there.
- R4: The command register keeps only bits 0 and 3 of the written byte (value AND 0x09) and reads back that value in the low byte. Bit 3 drives the direction output.
- R5: The host interrupt output follows the drive interrupt input in the same cycle. Each 0-to-1 change of the drive input sets the interrupt flag (status bit 2) at the next edge. A low input leaves the flag unchanged.
- R6: Writing the status byte with bit 2 set clears the interrupt flag, unless a new rising edge arrives in that same cycle, in which case the flag is set. Writes cannot change the active flag. All other status bits read as zero.
- R7: A base register write updates only the byte lanes whose enable is set. Bits 1:0 of the base always read as zero.
- R8: An engine done pulse with no further transfer pending clears the active flag. A done pulse with more pending leaves it set.
- R9: Reset clears the command, status, base and descriptor pointer. It cancels any active or draining transfer and holds kick and stop low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 status, 2 base |
| reg_wdata | input | 32 | Host write data |
| reg_be | input | 4 | Byte-lane enables for the write |
| reg_rdata | output | 32 | Read data for the selected register |
| eng_busy | input | 1 | Engine has a transfer in flight |
| eng_done | input | 1 | Engine completion pulse |
| eng_more | input | 1 | Further transfer pending, qualifies eng_done |
| eng_kick | output | 1 | One-cycle request to start the engine |
| eng_stop | output | 1 | One-cycle request to stop after the current transfer |
| dir_to_mem | output | 1 | Transfer direction from command bit 3 |
| desc_ptr | output | 32 | Current descriptor pointer |
| drv_irq | input | 1 | Interrupt level from the drive |
| host_irq | output | 1 | Interrupt level to the host |

## Verification
The assertions assume the engine raises eng_done only while the channel is active. They also assume eng_more has meaning only alongside eng_done, and that the host writes one register per cycle. The stimulus changes every input at the falling clock edge. It pulses done for a single cycle while active and leaves eng_busy low except inside the drain scenarios. The command sweep walks all 256 byte values with the engine idle, so every start-bit transition pattern arises from the preceding value.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_BASE = 2'd2
    } reg_sel_e;

    localparam int          START_BIT = 0;
    localparam int          DIR_BIT   = 3;
    localparam int          ACT_BIT   = 0;
    localparam int          INT_BIT   = 2;
    localparam logic [7:0]  CMD_KEEP  = 8'h09;

    typedef struct packed {
        logic rise;
        logic fall;
    } start_edge_t;

    function automatic start_edge_t classify_start(input logic wr,
                                                   input logic new_start,
                                                   input logic old_start);
        start_edge_t e;
        e.rise = wr && new_start && !old_start;
        e.fall = wr && !new_start && old_start;
        return e;
    endfunction

    function automatic logic [7:0] pack_status(input logic active,
                                               input logic intr);
        logic [7:0] s;
        s          = '0;
        s[ACT_BIT] = active;
        s[INT_BIT] = intr;
        return s;
    endfunction

endpackage

// File: rtl/bmdma_cmd_ctl.sv
module bmdma_cmd_ctl
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_wbyte,
    input  logic       eng_busy,
    input  logic       eng_done,
    input  logic       eng_more,
    output logic [7:0] cmd_q,
    output logic       active_q,
    output logic       kick_q,
    output logic       stop_q,
    output logic       reload
);

    start_edge_t sedge;
    logic        drain_q;

    assign sedge  = classify_start(cmd_wr, cmd_wbyte[START_BIT], cmd_q[START_BIT]);
    assign reload = sedge.rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            active_q <= 1'b0;
            drain_q  <= 1'b0;
            kick_q   <= 1'b0;
            stop_q   <= 1'b0;
        end else begin
            kick_q <= sedge.rise && !active_q;
            stop_q <= sedge.fall;
            if (cmd_wr) begin
                cmd_q <= cmd_wbyte & CMD_KEEP;
            end
            if (sedge.rise) begin
                active_q <= 1'b1;
                drain_q  <= 1'b0;
            end else if (sedge.fall) begin
                if (eng_busy) begin
                    drain_q <= 1'b1;
                end else begin
                    active_q <= 1'b0;
                end
            end else if (drain_q && !eng_busy) begin
                active_q <= 1'b0;
                drain_q  <= 1'b0;
            end else if (eng_done && !eng_more) begin
                active_q <= 1'b0;
                drain_q  <= 1'b0;
            end
        end
    end

    AST_SAME_START_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && (cmd_wbyte[START_BIT] == cmd_q[START_BIT])) |=> (!kick_q && !stop_q)); // R1

    AST_KICK_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        kick_q |-> (active_q && !$past(active_q))); // R2

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (active_q && eng_busy && !(eng_done && !eng_more)) |=> active_q); // R3

    AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !eng_more && !(cmd_wr && cmd_wbyte[START_BIT])) |=> !active_q); // R8

endmodule

// File: rtl/bmdma_irq_latch.sv
module bmdma_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic drv_irq,
    input  logic clr_req,
    output logic int_q
);

    logic prev_q;
    logic rise;

    assign rise = drv_irq && !prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            int_q  <= 1'b0;
        end else begin
            prev_q <= drv_irq;
            if (rise) begin
                int_q <= 1'b1;
            end else if (clr_req) begin
                int_q <= 1'b0;
            end
        end
    end

    AST_INT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (drv_irq && !prev_q) |=> int_q); // R5

    AST_INT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (int_q && !clr_req) |=> int_q); // R6

endmodule

// File: rtl/bmdma_base_reg.sv
module bmdma_base_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [LANES-1:0]  be,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              load,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] ptr_q
);

    localparam int LANES = ADDR_W / 8;

    logic [ADDR_W-1:0] base_d;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] lane_in;
        if (i == 0) begin : g_low
            assign lane_in = {wdata[7:2], 2'b00};
        end else begin : g_hi
            assign lane_in = wdata[i*8 +: 8];
        end
        assign base_d[i*8 +: 8] = (wr && be[i]) ? lane_in : base_q[i*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            ptr_q  <= '0;
        end else begin
            base_q <= base_d;
            if (load) begin
                ptr_q <= base_q;
            end
        end
    end

    AST_BASE_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(base_q)); // R7

endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [1:0]            reg_sel,
    input  logic [ADDR_W-1:0]     reg_wdata,
    input  logic [ADDR_W/8-1:0]   reg_be,
    output logic [ADDR_W-1:0]     reg_rdata,
    input  logic                  eng_busy,
    input  logic                  eng_done,
    input  logic                  eng_more,
    output logic                  eng_kick,
    output logic                  eng_stop,
    output logic                  dir_to_mem,
    output logic [ADDR_W-1:0]     desc_ptr,
    input  logic                  drv_irq,
    output logic                  host_irq
);

    reg_sel_e          sel;
    logic              cmd_wr;
    logic              stat_wr;
    logic              base_wr;
    logic [7:0]        cmd_q;
    logic              active_q;
    logic              int_q;
    logic              reload;
    logic [ADDR_W-1:0] base_q;

    assign sel     = reg_sel_e'(reg_sel);
    assign cmd_wr  = reg_wr && (sel == SEL_CMD)  && reg_be[0];
    assign stat_wr = reg_wr && (sel == SEL_STAT) && reg_be[0];
    assign base_wr = reg_wr && (sel == SEL_BASE);

    bmdma_cmd_ctl u_cmd (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .cmd_wbyte(reg_wdata[7:0]),
        .eng_busy (eng_busy),
        .eng_done (eng_done),
        .eng_more (eng_more),
        .cmd_q    (cmd_q),
        .active_q (active_q),
        .kick_q   (eng_kick),
        .stop_q   (eng_stop),
        .reload   (reload)
    );

    bmdma_irq_latch u_irq (
        .clk    (clk),
        .rst    (rst),
        .drv_irq(drv_irq),
        .clr_req(stat_wr && reg_wdata[INT_BIT]),
        .int_q  (int_q)
    );

    bmdma_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk   (clk),
        .rst   (rst),
        .wr    (base_wr),
        .be    (reg_be),
        .wdata (reg_wdata),
        .load  (reload),
        .base_q(base_q),
        .ptr_q (desc_ptr)
    );

    assign host_irq   = drv_irq;
    assign dir_to_mem = cmd_q[DIR_BIT];

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_CMD:  reg_rdata[7:0] = cmd_q;
            SEL_STAT: reg_rdata[7:0] = pack_status(active_q, int_q);
            SEL_BASE: reg_rdata      = base_q;
            default:  reg_rdata      = '0;
        endcase
    end

endmodule

// File: tb/bmdma_regs_tb.sv
module bmdma_regs_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_rdata;
    logic        eng_busy = 1'b0;
    logic        eng_done = 1'b0;
    logic        eng_more = 1'b0;
    logic        eng_kick, eng_stop, dir_to_mem, host_irq;
    logic [31:0] desc_ptr;
    logic        drv_irq = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bmdma_regs dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_more(eng_more),
        .eng_kick(eng_kick), .eng_stop(eng_stop), .dir_to_mem(dir_to_mem),
        .desc_ptr(desc_ptr), .drv_irq(drv_irq), .host_irq(host_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic [31:0] base_m;
        logic [7:0]  cmd_m;
        logic        act_m;

        tick(3);
        @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        rd(2'd0, r); chk("R9 cmd after reset", r, 32'h0);
        rd(2'd1, r); chk("R9 status after reset", r, 32'h0);
        rd(2'd2, r); chk("R9 base after reset", r, 32'h0);
        chk("R9 ptr after reset", desc_ptr, 32'h0);
        chk("R9 kick/stop after reset", {30'b0, eng_kick, eng_stop}, 32'h0);

        // R7 byte-lane sweep
        base_m = '0;
        for (int be = 0; be < 16; be++) begin
            logic [31:0] d;
            d = 32'hA5C3_0F5B ^ (32'h1111_1111 * be);
            wr(2'd2, d, be[3:0]);
            for (int l = 0; l < 4; l++)
                if (be[l]) base_m[l*8 +: 8] = d[l*8 +: 8];
            base_m[1:0] = 2'b00;
            rd(2'd2, r); chk("R7 base lanes", r, base_m);
        end
        wr(2'd2, 32'h8000_1003, 4'hF);
        base_m = 32'h8000_1000;
        rd(2'd2, r); chk("R7 low bits forced zero", r, base_m);

        // R4/R2/R1/R3 command sweep, engine idle
        cmd_m = 8'h00; act_m = 1'b0;
        for (int v = 0; v < 256; v++) begin
            logic rise, fall, ek;
            rise = v[0] && !cmd_m[0];
            fall = !v[0] && cmd_m[0];
            ek = rise && !act_m;
            if (rise) act_m = 1'b1;
            else if (fall) act_m = 1'b0;
            cmd_m = v[7:0] & 8'h09;
            wr(2'd0, v, 4'h1);
            chk("R2 R1 kick on start edge", {31'b0, eng_kick}, {31'b0, ek});
            chk("R3 R1 stop on clear edge", {31'b0, eng_stop}, {31'b0, fall});
            rd(2'd0, r); chk("R4 cmd masked", r, {24'b0, cmd_m});
            chk("R4 direction bit", {31'b0, dir_to_mem}, {31'b0, cmd_m[3]});
            rd(2'd1, r); chk("R2 R3 active flag", r, {31'b0, act_m});
            if (rise) chk("R2 ptr reloaded", desc_ptr, base_m);
        end

        // R1 same start while active: no reload
        wr(2'd0, 32'h0, 4'h1);
        wr(2'd0, 32'h1, 4'h1);
        chk("R2 kick from idle", {31'b0, eng_kick}, 32'h1);
        wr(2'd2, 32'h0000_4440, 4'hF);
        wr(2'd0, 32'h9, 4'h1);
        chk("R1 no kick same start", {31'b0, eng_kick}, 32'h0);
        chk("R1 ptr not reloaded", desc_ptr, base_m);
        rd(2'd1, r); chk("R1 active unchanged", r, 32'h1);
        base_m = 32'h0000_4440;

        // R3 drain: stop while busy
        @(negedge clk); eng_busy = 1'b1;
        wr(2'd0, 32'h0, 4'h1);
        chk("R3 stop pulse", {31'b0, eng_stop}, 32'h1);
        tick(3);
        rd(2'd1, r); chk("R3 active held while busy", r, 32'h1);
        eng_busy = 1'b0;
        tick(1);
        rd(2'd1, r); chk("R3 active clears when idle", r, 32'h0);

        // R2 restart during drain: reload, no kick, stays active
        wr(2'd0, 32'h1, 4'h1);
        @(negedge clk); eng_busy = 1'b1;
        wr(2'd0, 32'h0, 4'h1);
        wr(2'd2, 32'h0000_7700, 4'hF);
        base_m = 32'h0000_7700;
        wr(2'd0, 32'h1, 4'h1);
        chk("R2 no kick when already active", {31'b0, eng_kick}, 32'h0);
        chk("R2 ptr reloaded during drain", desc_ptr, base_m);
        eng_busy = 1'b0;
        tick(2);
        rd(2'd1, r); chk("R2 restart cancels drain", r, 32'h1);

        // R8 done handling
        eng_done = 1'b1; eng_more = 1'b1;
        tick(1);
        eng_done = 1'b0; eng_more = 1'b0;
        rd(2'd1, r); chk("R8 done with more keeps active", r, 32'h1);
        eng_done = 1'b1;
        tick(1);
        eng_done = 1'b0;
        rd(2'd1, r); chk("R8 done retires", r, 32'h0);

        // R5/R6 interrupt
        drv_irq = 1'b1;
        #1 chk("R5 host irq follows", {31'b0, host_irq}, 32'h1);
        tick(1);
        rd(2'd1, r); chk("R5 int flag set", r, 32'h4);
        wr(2'd1, 32'h4, 4'h1);
        rd(2'd1, r); chk("R6 w1c clears", r, 32'h0);
        tick(2);
        rd(2'd1, r); chk("R6 level high no re-set", r, 32'h0);
        wr(2'd1, 32'h1, 4'h1);
        rd(2'd1, r); chk("R6 active read-only", r, 32'h0);
        drv_irq = 1'b0;
        #1 chk("R5 host irq low", {31'b0, host_irq}, 32'h0);
        tick(1);
        rd(2'd1, r); chk("R5 low level no change", r, 32'h0);
        @(negedge clk);
        drv_irq = 1'b1; reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 32'h4; reg_be = 4'h1;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0;
        rd(2'd1, r); chk("R6 rise beats clear", r, 32'h4);

        // R9 reset mid-operation
        wr(2'd0, 32'h9, 4'h1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; drv_irq = 1'b0;
        rd(2'd0, r); chk("R9 cmd cleared", r, 32'h0);
        rd(2'd1, r); chk("R9 status cleared", r, 32'h0);
        rd(2'd2, r); chk("R9 base cleared", r, 32'h0);
        chk("R9 ptr cleared", desc_ptr, 32'h0);

        finish_run();
    end

endmodule